// File: doc/BRIEF.md
# Stereo Serial Audio Receiver

This block turns a three-wire stereo audio stream (bit clock, channel select, serial data) into parallel left and right samples of a fixed width `W`. All three wires are treated as asynchronous. They pass through two-flop synchronisers into the system clock, and a rising edge of the bit clock is detected there. The data line is sampled only at those edges.

Each word is framed by changes of the channel-select line alone. The bit that arrives on the edge where a change is first seen is the last bit of the old word. The next bit is the most significant bit of the new word. The receiver never needs to know how long the sender's words are: bits beyond `W` are dropped, and a word cut short is padded with zeros.

When a right word completes after a full left word, both samples appear together with a one-cycle strobe. A consumer acknowledges each pair. If a fresh pair lands before the previous one was acknowledged, a sticky overrun flag is raised.

Top module: `audio_sr_rx`

## Requirements
- R1: The data line is taken only at rising bit-clock edges. Data changes while the bit clock is high, after its rising edge, have no effect on the samples.
- R2: A channel-select change first observed at a rising edge marks that edge's bit as the final bit of the old word. The bit taken at the following rising edge is bit `W-1` (MSB) of the new word. A word of exactly `W` bits is reproduced unchanged.
- R3: When a word carries more than `W` bits, only its first `W` bits are kept and the rest are discarded.
- R4: When a word carries fewer than `W` bits, those bits fill the top of the sample and every lower bit is 0.
- R5: A word sent while channel select is 0 appears on `left_out`; a word sent while it is 1 appears on `right_out`.
- R6: Framing relies only on channel-select transitions. Left and right words of different lengths, including a 3-bit word, are received correctly.
- R7: After reset, bits before the first channel-select transition are discarded. No pair is presented until a complete left word has been followed by a complete right word.
- R8: `pair_valid` is a one-cycle pulse in the third system clock cycle after the bit-clock rise that carries the right word's final bit. `left_out` and `right_out` change only with that pulse and hold their values between pulses.
- R9: A pair is pending from its strobe until `pair_ack` is sampled high. If a new pair completes while one is pending and `pair_ack` is low in that cycle, `overrun` goes to 1 and stays there until reset.
- R10: While reset is asserted, `left_out`, `right_out`, `pair_valid` and `overrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | Serial bit clock, asynchronous |
| lrsel_in | input | 1 | Channel select: 0 left, 1 right; asynchronous |
| sdata_in | input | 1 | Serial data, MSB first; asynchronous |
| pair_ack | input | 1 | Consumer has taken the current pair |
| left_out | output | W | Left sample of the last pair |
| right_out | output | W | Right sample of the last pair |
| pair_valid | output | 1 | One-cycle strobe for a new pair |
| overrun | output | 1 | Sticky: a pair arrived before the previous one was acknowledged |

## Verification
A broken bit counter or a misplaced MSB shows up on the sample outputs at the next strobe. This is no later than one stereo frame after the fault. The expected values are built from the bits the bench sent and the word length it used, so truncation and zero-fill errors show directly.

A wrong framing state (a missed channel-select edge, or a stale "left seen" flag) shows as a strobe at the wrong clock or a missing one. The strobe is compared on every cycle, so a one-cycle shift in the synchroniser path is caught at once. Overrun and pending state are checked every cycle against an independent model, with acknowledgement both present and withheld.

// File: rtl/audio_sr_rx.sv
module audio_sr_rx #(
  parameter int W    = 16,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bclk_in,
  input  logic         lrsel_in,
  input  logic         sdata_in,
  input  logic         pair_ack,
  output logic [W-1:0] left_out,
  output logic [W-1:0] right_out,
  output logic         pair_valid,
  output logic         overrun
);

  localparam int            CW  = $clog2(W + 1);
  localparam logic [CW-1:0] LIM = CW'(W);
  localparam logic [CW-1:0] TOP = CW'(W - 1);

  logic [SYNC-1:0] bclk_sh, ws_sh, sd_sh;
  logic            bclk_d, ws_last, ws_known, armed, have_left, pending;
  logic [CW-1:0]   cnt;
  logic [W-1:0]    acc, left_hold;

  wire bclk_s = bclk_sh[SYNC-1];
  wire ws_s   = ws_sh[SYNC-1];
  wire sd_s   = sd_sh[SYNC-1];
  wire rise   = bclk_s & ~bclk_d;

  wire         ws_edge = ws_known && (ws_s != ws_last);
  wire [W-1:0] bitpos  = {{(W-1){1'b0}}, 1'b1} << (TOP - cnt);
  wire [W-1:0] word    = acc | ((sd_s && cnt < LIM) ? bitpos : '0);

  wire done_l   = rise & ws_edge & armed & ~ws_last;
  wire done_r   = rise & ws_edge & armed &  ws_last;
  wire new_pair = done_r & have_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_sh <= '0;
      ws_sh   <= '0;
      sd_sh   <= '0;
      bclk_d  <= 1'b0;
    end else begin
      bclk_sh <= {bclk_sh[SYNC-2:0], bclk_in};
      ws_sh   <= {ws_sh[SYNC-2:0], lrsel_in};
      sd_sh   <= {sd_sh[SYNC-2:0], sdata_in};
      bclk_d  <= bclk_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_last  <= 1'b0;
      ws_known <= 1'b0;
      armed    <= 1'b0;
      cnt      <= '0;
      acc      <= '0;
    end else if (rise) begin
      ws_last  <= ws_s;
      ws_known <= 1'b1;
      if (ws_edge) begin
        armed <= 1'b1;
        cnt   <= '0;
        acc   <= '0;
      end else begin
        acc <= word;
        if (cnt < LIM) cnt <= cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_hold  <= '0;
      have_left  <= 1'b0;
      left_out   <= '0;
      right_out  <= '0;
      pair_valid <= 1'b0;
      pending    <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      pair_valid <= new_pair;
      if (done_l) begin
        left_hold <= word;
        have_left <= 1'b1;
      end else if (done_r) begin
        have_left <= 1'b0;
      end
      if (new_pair) begin
        left_out  <= left_hold;
        right_out <= word;
        pending   <= 1'b1;
        if (pending && !pair_ack) overrun <= 1'b1;
      end else if (pair_ack) begin
        pending <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/audio_sr_rx_chk.sv
module audio_sr_rx_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pair_valid,
  input logic         overrun,
  input logic [W-1:0] left_out,
  input logic [W-1:0] right_out
);

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid);                                         // R8

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_valid |-> ($stable(left_out) && $stable(right_out)));          // R8

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);                                                // R9

  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> pair_valid);                                      // R9

  always @(posedge clk)
    if (!rst_n)
      AST_RESET_QUIET: assert (!pair_valid && !overrun && left_out == '0 && right_out == '0); // R10

endmodule

bind audio_sr_rx audio_sr_rx_chk #(.W(W)) u_chk (.*);

// File: tb/test_audio_sr_rx.sv
module test_audio_sr_rx;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk_in = 1'b0, lrsel_in = 1'b0, sdata_in = 1'b0, pair_ack = 1'b0;
  logic [W-1:0] left_out, right_out;
  logic pair_valid, overrun;

  audio_sr_rx #(.W(W)) i_audio_sr_rx (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .lrsel_in(lrsel_in),
    .sdata_in(sdata_in), .pair_ack(pair_ack), .left_out(left_out),
    .right_out(right_out), .pair_valid(pair_valid), .overrun(overrun));

  always #2 clk = ~clk;

  int vectors = 0, errors = 0, cyc = 0;
  string cur_req = "R2";
  bit auto_ack = 1'b1, noisy = 1'b0, done = 1'b0;
  int due_q[$];
  logic [W-1:0] expl_q[$], expr_q[$];
  logic [W-1:0] cur_l = '0, cur_r = '0;
  bit m_pend = 1'b0, m_ovr = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [W-1:0] expw(input logic [63:0] v, input int n);
    logic [W-1:0] r = '0;
    for (int b = 0; b < W; b++) begin
      int idx = n - 1 - b;
      if (idx >= 0) r[W-1-b] = v[idx];
    end
    return r;
  endfunction

  task automatic fail(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    errors++;
    $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
  endtask

  // reference model, compared on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_v;
      bit ack_applied;
      ack_applied = pair_ack;
      exp_v = (due_q.size() > 0) && (due_q[0] == cyc);
      if (exp_v) begin
        void'(due_q.pop_front());
        cur_l = expl_q.pop_front();
        cur_r = expr_q.pop_front();
        if (m_pend && !ack_applied) m_ovr = 1'b1;
        m_pend = 1'b1;
      end else if (ack_applied) begin
        m_pend = 1'b0;
      end
      vectors++;
      if (pair_valid !== exp_v) fail("R8", "pair_valid", pair_valid, exp_v);
      if (left_out !== cur_l) fail(cur_req, "left_out (R5)", left_out, cur_l);
      if (right_out !== cur_r) fail(cur_req, "right_out (R5)", right_out, cur_r);
      if (overrun !== m_ovr) fail("R9", "overrun", overrun, m_ovr);
      pair_ack = auto_ack && exp_v;
    end
  end

  task automatic slot(input logic ws, input logic d, input bit mark, input logic [W-1:0] l, input logic [W-1:0] r);
    @(negedge clk);
    bclk_in = 1'b0; lrsel_in = ws; sdata_in = d;
    repeat (3) @(negedge clk);
    bclk_in = 1'b1;
    if (mark) begin
      due_q.push_back(cyc + 3);
      expl_q.push_back(l);
      expr_q.push_back(r);
    end
    repeat (2) @(negedge clk);
    if (noisy) sdata_in = ~d;   // R1: change while clock is high
    @(negedge clk);
  endtask

  task automatic send_word(input bit ch, input logic [63:0] v, input int n, input bit nxt,
                           input bit mark, input logic [W-1:0] l);
    for (int i = 0; i < n; i++)
      slot((i == n - 1) ? nxt : ch, v[n-1-i], mark && (i == n - 1), l, expw(v, n));
  endtask

  task automatic send_pair(input logic [63:0] lv, input int ln, input logic [63:0] rv, input int rn);
    send_word(1'b0, lv, ln, 1'b1, 1'b0, '0);
    send_word(1'b1, rv, rn, 1'b0, 1'b1, expw(lv, ln));
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; bclk_in = 1'b0; lrsel_in = 1'b0; sdata_in = 1'b0; pair_ack = 1'b0;
    due_q.delete(); expl_q.delete(); expr_q.delete();
    cur_l = '0; cur_r = '0; m_pend = 1'b0; m_ovr = 1'b0;
    repeat (4) @(negedge clk);
    vectors++;
    if (pair_valid !== 1'b0 || overrun !== 1'b0 || left_out !== '0 || right_out !== '0)
      fail("R10", "reset outputs", {pair_valid, overrun, left_out, right_out}, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fail("watchdog", "run did not finish", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R7: stray left bits, then a right word with no left before it
    cur_req = "R7";
    send_word(1'b0, 64'h2D, 6, 1'b1, 1'b0, '0);
    send_word(1'b1, 64'hBEEF, 16, 1'b0, 1'b0, '0);
    cur_req = "R2";
    send_pair(64'hA5C3, 16, 64'h1234, 16);
    cur_req = "R5";
    send_pair(64'h0F0F, 16, 64'hF0F0, 16);
    cur_req = "R3";
    send_pair(64'hABCDEF, 24, 64'h876543, 24);
    cur_req = "R4";
    send_pair(64'hC7, 8, 64'h5A, 8);
    cur_req = "R6";
    send_pair(64'h5, 3, 64'hDEAD_BEEF, 32);
    send_pair(64'h9ABCD, 20, 64'h3F, 7);
    cur_req = "R1";
    noisy = 1'b1;
    send_pair(64'h6B2E, 16, 64'h91D4, 16);
    noisy = 1'b0;
    // R9: withhold acknowledgement, then resume; flag must stay set
    cur_req = "R9";
    auto_ack = 1'b0;
    send_pair(64'h1111, 16, 64'h2222, 16);
    send_pair(64'h3333, 16, 64'h4444, 16);
    auto_ack = 1'b1;
    send_pair(64'h5555, 16, 64'h6666, 16);
    send_word(1'b0, 64'h0, 4, 1'b0, 1'b0, '0);
    // R10 and R7 again after a second reset
    do_reset();
    cur_req = "R7";
    send_word(1'b1, 64'h3, 3, 1'b0, 1'b0, '0);
    send_pair(64'h7E81, 16, 64'h0180, 12);
    send_word(1'b0, 64'h0, 4, 1'b0, 1'b0, '0);
    repeat (8) @(negedge clk);
    vectors++;
    if (due_q.size() != 0) fail("R8", "strobes never seen", due_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule